// File: doc/BRIEF.md
# Column-Pipelined Configuration Distributor

This block drives a configuration word into every processing element of a 4x4 array on every clock. It has two stores. The spatial store holds one word per PE per context. The temporal store holds one word per row per context. A single context counter selects the context for both stores.

In spatial mode, every PE register loads its own word from the spatial store, so each PE can run a different operation on every cycle. In temporal mode, only the first column reads from the temporal store. Each later column takes the word its left neighbour held one cycle earlier. A row therefore repeats one operation, skewed by one cycle per column, while the store delivers only four words per cycle instead of sixteen.

A direct switch from temporal to spatial mode spends one cycle clearing the whole array to the no-operation word. While the array is not running, every output is the no-operation word, which is zero. A read counter reports how many store words fed the most recent update, so the saving in reads can be observed.

Top module: `cdist_top`

## Requirements
- R1: While reset is asserted, every PE word on `pe_cfg_o` is zero and `rd_count_o` is zero.
- R2: After a clock edge at which `run_i` is low, every PE word is zero and `rd_count_o` is zero. The context counter returns to 0.
- R3: The first active edge after idle or reset reads context 0. Each active edge advances the context by one and wraps from 7 to 0. The same counter serves both stores, and a flush edge also advances it.
- R4: An active edge with `temporal_i` low, other than a flush edge, loads PE (r,c) with spatial word (context, lane r*4+c). PE (r,c) is driven on `pe_cfg_o[(r*4+c)*16 +: 16]`.
- R5: An active edge with `temporal_i` high loads PE (r,0) with temporal word (context, row r).
- R6: On the same temporal edge, PE (r,c) for c from 1 to 3 loads the word that PE (r,c-1) held before the edge.
- R7: An active spatial edge that directly follows an active temporal edge loads zero into all PEs. Spatial words appear from the next active edge.
- R8: `rd_count_o` gives the number of store words used by the last update: 16 for spatial, 4 for temporal, and 0 for flush or idle.
- R9: A write at an edge stores (context, index) ← data. The spatial write uses a PE index of r*4+c, and the temporal write uses a row index. A read at that same edge returns the word held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Array active when high |
| temporal_i | input | 1 | 1 = temporal (column-pipelined) mode, 0 = spatial mode |
| sp_wr_en_i | input | 1 | Spatial store write enable |
| sp_wr_ctx_i | input | 3 | Spatial write context |
| sp_wr_pe_i | input | 4 | Spatial write PE index r*4+c |
| sp_wr_data_i | input | 16 | Spatial write word |
| tp_wr_en_i | input | 1 | Temporal store write enable |
| tp_wr_ctx_i | input | 3 | Temporal write context |
| tp_wr_row_i | input | 2 | Temporal write row |
| tp_wr_data_i | input | 16 | Temporal write word |
| pe_cfg_o | output | 256 | Per-PE configuration words, PE (r,c) at bits (r*4+c)*16 |
| rd_count_o | output | 5 | Store words read for the last update |

## Verification
Each stored word carries a code for its context and its lane. A context counter that is off by one therefore shows up as wrong words on every PE at the very next active edge. A broken shift chain puts a word in the wrong column within one to three cycles of temporal operation. A missed or extra flush shows up at the one edge that follows a mode change.

The bench drives the block with long runs and with random mixes of mode changes, idle gaps and writes that collide with the context being read. It compares all 256 output bits and the read count after every edge against a behavioural model.

// File: rtl/cdist_pkg.sv
package cdist_pkg;
  typedef enum logic [1:0] {
    UPD_IDLE     = 2'd0,
    UPD_SPATIAL  = 2'd1,
    UPD_TEMPORAL = 2'd2,
    UPD_FLUSH    = 2'd3
  } upd_kind_e;
endpackage

// File: rtl/cdist_store.sv
module cdist_store #(
  parameter int LANES     = 16,
  parameter int WORD_W    = 16,
  parameter int CTX_DEPTH = 8,
  localparam int LANE_W   = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int CTX_W    = (CTX_DEPTH > 1) ? $clog2(CTX_DEPTH) : 1,
  localparam int ENTRIES  = CTX_DEPTH * LANES
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [CTX_W-1:0]        wr_ctx,
  input  logic [LANE_W-1:0]       wr_lane,
  input  logic [WORD_W-1:0]       wr_data,
  input  logic [CTX_W-1:0]        rd_ctx,
  output logic [LANES*WORD_W-1:0] rd_words
);
  logic [WORD_W-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[int'(wr_ctx) * LANES + int'(wr_lane)] <= wr_data;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign rd_words[l*WORD_W +: WORD_W] = mem[int'(rd_ctx) * LANES + l];
  end
endmodule

// File: rtl/cdist_ctx_ctl.sv
module cdist_ctx_ctl
  import cdist_pkg::*;
#(
  parameter int CTX_DEPTH = 8,
  localparam int CTX_W    = (CTX_DEPTH > 1) ? $clog2(CTX_DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             temporal,
  output logic [CTX_W-1:0] ctx,
  output upd_kind_e        kind
);
  localparam logic [CTX_W-1:0] CTX_LAST = CTX_W'(CTX_DEPTH - 1);

  logic [CTX_W-1:0] ctx_q, ctx_d;
  logic             last_temp_q, last_temp_d;

  always_comb begin
    if (!run)                        kind = UPD_IDLE;
    else if (temporal)               kind = UPD_TEMPORAL;
    else if (last_temp_q)            kind = UPD_FLUSH;
    else                             kind = UPD_SPATIAL;
  end

  always_comb begin
    ctx_d       = ctx_q;
    last_temp_d = run && temporal;
    if (!run)                    ctx_d = '0;
    else if (ctx_q == CTX_LAST)  ctx_d = '0;
    else                         ctx_d = ctx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctx_q       <= '0;
      last_temp_q <= 1'b0;
    end else begin
      ctx_q       <= ctx_d;
      last_temp_q <= last_temp_d;
    end
  end

  assign ctx = ctx_q;

  AST_CTX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && ctx_q == CTX_LAST) |=> (ctx_q == '0)); // R3
  AST_CTX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && ctx_q != CTX_LAST) |=> (ctx_q == $past(ctx_q) + 1'b1)); // R3
  AST_IDLE_CTX: assert property (@(posedge clk) disable iff (!rst_n)
    (!run) |=> (ctx_q == '0)); // R2
endmodule

// File: rtl/cdist_col_pipe.sv
module cdist_col_pipe
  import cdist_pkg::*;
#(
  parameter int ROWS   = 4,
  parameter int COLS   = 4,
  parameter int WORD_W = 16,
  localparam int NPE   = ROWS * COLS,
  localparam int CNT_W = $clog2(NPE + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  upd_kind_e              kind,
  input  logic [NPE*WORD_W-1:0]  sp_words,
  input  logic [ROWS*WORD_W-1:0] tp_words,
  output logic [NPE*WORD_W-1:0]  cfg,
  output logic [CNT_W-1:0]       rd_count
);
  logic [NPE*WORD_W-1:0] cfg_q, cfg_d;
  logic [CNT_W-1:0]      cnt_q, cnt_d;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int IDX = r * COLS + c;
      logic [WORD_W-1:0] src_t;
      if (c == 0) begin : g_head
        assign src_t = tp_words[r*WORD_W +: WORD_W];
      end else begin : g_tail
        assign src_t = cfg_q[(IDX-1)*WORD_W +: WORD_W];
        AST_COL_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
          (kind == UPD_TEMPORAL) |=>
          (cfg_q[IDX*WORD_W +: WORD_W] == $past(cfg_q[(IDX-1)*WORD_W +: WORD_W]))); // R6
      end
      assign cfg_d[IDX*WORD_W +: WORD_W] =
        (kind == UPD_SPATIAL)  ? sp_words[IDX*WORD_W +: WORD_W] :
        (kind == UPD_TEMPORAL) ? src_t : '0;
    end
  end

  always_comb begin
    unique case (kind)
      UPD_SPATIAL:  cnt_d = CNT_W'(NPE);
      UPD_TEMPORAL: cnt_d = CNT_W'(ROWS);
      default:      cnt_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      cnt_q <= '0;
    end else begin
      cfg_q <= cfg_d;
      cnt_q <= cnt_d;
    end
  end

  assign cfg      = cfg_q;
  assign rd_count = cnt_q;

  AST_NOP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == UPD_IDLE || kind == UPD_FLUSH) |=> (cfg_q == '0 && cnt_q == '0)); // R7
  AST_TEMP_READS: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == UPD_TEMPORAL) |=> (cnt_q == CNT_W'(ROWS))); // R8
endmodule

// File: rtl/cdist_top.sv
module cdist_top
  import cdist_pkg::*;
#(
  parameter int ROWS      = 4,
  parameter int COLS      = 4,
  parameter int WORD_W    = 16,
  parameter int CTX_DEPTH = 8,
  localparam int NPE      = ROWS * COLS,
  localparam int CTX_W    = (CTX_DEPTH > 1) ? $clog2(CTX_DEPTH) : 1,
  localparam int PE_W     = (NPE > 1) ? $clog2(NPE) : 1,
  localparam int ROW_W    = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CNT_W    = $clog2(NPE + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run_i,
  input  logic                  temporal_i,
  input  logic                  sp_wr_en_i,
  input  logic [CTX_W-1:0]      sp_wr_ctx_i,
  input  logic [PE_W-1:0]       sp_wr_pe_i,
  input  logic [WORD_W-1:0]     sp_wr_data_i,
  input  logic                  tp_wr_en_i,
  input  logic [CTX_W-1:0]      tp_wr_ctx_i,
  input  logic [ROW_W-1:0]      tp_wr_row_i,
  input  logic [WORD_W-1:0]     tp_wr_data_i,
  output logic [NPE*WORD_W-1:0] pe_cfg_o,
  output logic [CNT_W-1:0]      rd_count_o
);
  logic [CTX_W-1:0]       ctx;
  upd_kind_e              kind;
  logic [NPE*WORD_W-1:0]  sp_words;
  logic [ROWS*WORD_W-1:0] tp_words;

  cdist_ctx_ctl #(.CTX_DEPTH(CTX_DEPTH)) ctl_i (
    .clk(clk), .rst_n(rst_n), .run(run_i), .temporal(temporal_i),
    .ctx(ctx), .kind(kind)
  );

  cdist_store #(.LANES(NPE), .WORD_W(WORD_W), .CTX_DEPTH(CTX_DEPTH)) sp_store_i (
    .clk(clk), .wr_en(sp_wr_en_i), .wr_ctx(sp_wr_ctx_i), .wr_lane(sp_wr_pe_i),
    .wr_data(sp_wr_data_i), .rd_ctx(ctx), .rd_words(sp_words)
  );

  cdist_store #(.LANES(ROWS), .WORD_W(WORD_W), .CTX_DEPTH(CTX_DEPTH)) tp_store_i (
    .clk(clk), .wr_en(tp_wr_en_i), .wr_ctx(tp_wr_ctx_i), .wr_lane(tp_wr_row_i),
    .wr_data(tp_wr_data_i), .rd_ctx(ctx), .rd_words(tp_words)
  );

  cdist_col_pipe #(.ROWS(ROWS), .COLS(COLS), .WORD_W(WORD_W)) pipe_i (
    .clk(clk), .rst_n(rst_n), .kind(kind), .sp_words(sp_words),
    .tp_words(tp_words), .cfg(pe_cfg_o), .rd_count(rd_count_o)
  );

  AST_FLUSH_ON_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && temporal_i) ##1 (run_i && !temporal_i) |=> (pe_cfg_o == '0)); // R7
  AST_IDLE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i) |=> (pe_cfg_o == '0 && rd_count_o == '0)); // R2
  AST_RESET_NOP: assert property (@(posedge clk)
    (!rst_n) |-> (pe_cfg_o == '0 && rd_count_o == '0)); // R1
endmodule

// File: tb/cdist_top_tb.sv
module cdist_top_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         run_i = 1'b0, temporal_i = 1'b0;
  logic         sp_wr_en_i = 1'b0, tp_wr_en_i = 1'b0;
  logic [2:0]   sp_wr_ctx_i = '0, tp_wr_ctx_i = '0;
  logic [3:0]   sp_wr_pe_i = '0;
  logic [1:0]   tp_wr_row_i = '0;
  logic [15:0]  sp_wr_data_i = '0, tp_wr_data_i = '0;
  logic [255:0] pe_cfg_o;
  logic [4:0]   rd_count_o;

  int n_cmp = 0, n_bad = 0;

  always #2 clk = ~clk;

  cdist_top dut_i (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .temporal_i(temporal_i),
    .sp_wr_en_i(sp_wr_en_i), .sp_wr_ctx_i(sp_wr_ctx_i), .sp_wr_pe_i(sp_wr_pe_i),
    .sp_wr_data_i(sp_wr_data_i), .tp_wr_en_i(tp_wr_en_i), .tp_wr_ctx_i(tp_wr_ctx_i),
    .tp_wr_row_i(tp_wr_row_i), .tp_wr_data_i(tp_wr_data_i),
    .pe_cfg_o(pe_cfg_o), .rd_count_o(rd_count_o)
  );

  // behavioural reference
  logic [15:0] m_sp [8][16];
  logic [15:0] m_tp [8][4];
  logic [15:0] m_cfg [16];
  int          m_ctx = 0, m_rd = 0;
  bit          m_last_temp = 0;
  string       m_tag = "R1";

  always @(posedge clk) begin
    logic [15:0] nxt [16];
    if (!rst_n) begin
      for (int k = 0; k < 16; k++) m_cfg[k] = '0;
      m_ctx = 0; m_rd = 0; m_last_temp = 0; m_tag = "R1";
    end else begin
      if (!run_i) begin
        for (int k = 0; k < 16; k++) nxt[k] = '0;
        m_rd = 0; m_tag = "R2";
      end else if (!temporal_i && m_last_temp) begin
        for (int k = 0; k < 16; k++) nxt[k] = '0;
        m_rd = 0; m_tag = "R7";
      end else if (temporal_i) begin
        for (int r = 0; r < 4; r++) begin
          nxt[r*4] = m_tp[m_ctx][r];
          for (int c = 1; c < 4; c++) nxt[r*4+c] = m_cfg[r*4+c-1];
        end
        m_rd = 4; m_tag = "R5 R6 R3";
        if (tp_wr_en_i && int'(tp_wr_ctx_i) == m_ctx) m_tag = "R9";
      end else begin
        for (int k = 0; k < 16; k++) nxt[k] = m_sp[m_ctx][k];
        m_rd = 16; m_tag = "R4 R3";
        if (sp_wr_en_i && int'(sp_wr_ctx_i) == m_ctx) m_tag = "R9";
      end
      for (int k = 0; k < 16; k++) m_cfg[k] = nxt[k];
      if (sp_wr_en_i) m_sp[sp_wr_ctx_i][sp_wr_pe_i] = sp_wr_data_i;
      if (tp_wr_en_i) m_tp[tp_wr_ctx_i][tp_wr_row_i] = tp_wr_data_i;
      m_ctx = run_i ? (m_ctx + 1) % 8 : 0;
      m_last_temp = run_i && temporal_i;
    end
  end

  task automatic compare();
    n_cmp++;
    for (int k = 0; k < 16; k++) begin
      if (pe_cfg_o[k*16 +: 16] !== m_cfg[k]) begin
        n_bad++;
        $display("FAIL %s PE%0d actual=%h expected=%h t=%0t", m_tag, k,
                 pe_cfg_o[k*16 +: 16], m_cfg[k], $time);
        break;
      end
    end
    n_cmp++;
    if (int'(rd_count_o) != m_rd) begin
      n_bad++;
      $display("FAIL R8 rd_count actual=%0d expected=%0d t=%0t", rd_count_o, m_rd, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    n_cmp++;
    if (pe_cfg_o !== '0 || rd_count_o !== '0) begin
      n_bad++;
      $display("FAIL R1 reset actual=%h/%0d expected=0/0", pe_cfg_o, rd_count_o);
    end
    rst_n = 1'b1;
    tick();

    // fill both stores while idle (R2, R9)
    for (int x = 0; x < 8; x++) begin
      for (int p = 0; p < 16; p++) begin
        sp_wr_en_i = 1; sp_wr_ctx_i = 3'(x); sp_wr_pe_i = 4'(p);
        sp_wr_data_i = 16'h1000 | 16'(x << 8) | 16'(p);
        tick();
      end
    end
    sp_wr_en_i = 0;
    for (int x = 0; x < 8; x++) begin
      for (int r = 0; r < 4; r++) begin
        tp_wr_en_i = 1; tp_wr_ctx_i = 3'(x); tp_wr_row_i = 2'(r);
        tp_wr_data_i = 16'h2000 | 16'(x << 8) | 16'(r << 4);
        tick();
      end
    end
    tp_wr_en_i = 0;

    // R4/R3: spatial across a wrap
    run_i = 1; temporal_i = 0;
    repeat (20) tick();
    // R5/R6: temporal, pipeline fill and steady state
    temporal_i = 1;
    repeat (12) tick();
    // R7: direct switch back to spatial
    temporal_i = 0;
    repeat (5) tick();
    // temporal, idle gap, temporal again (R2)
    temporal_i = 1;
    repeat (6) tick();
    run_i = 0;
    repeat (3) tick();
    run_i = 1;
    repeat (6) tick();
    // R9: write to the context being read
    temporal_i = 0;
    tick();
    sp_wr_en_i = 1; sp_wr_ctx_i = 3'(m_ctx); sp_wr_pe_i = 4'd5; sp_wr_data_i = 16'hBEEF;
    tick();
    sp_wr_en_i = 0;
    repeat (9) tick();

    // random mix
    for (int i = 0; i < 500; i++) begin
      run_i = ($urandom_range(0, 7) != 0);
      if ($urandom_range(0, 5) == 0) temporal_i = ~temporal_i;
      sp_wr_en_i   = ($urandom_range(0, 3) == 0);
      sp_wr_ctx_i  = 3'($urandom_range(0, 7));
      sp_wr_pe_i   = 4'($urandom_range(0, 15));
      sp_wr_data_i = 16'($urandom);
      tp_wr_en_i   = ($urandom_range(0, 3) == 0);
      tp_wr_ctx_i  = 3'($urandom_range(0, 7));
      tp_wr_row_i  = 2'($urandom_range(0, 3));
      tp_wr_data_i = 16'($urandom);
      tick();
    end
    finish_run();
  end
endmodule